// File: doc/BRIEF.md
# Exception Entry and Return Sequencer

This block decides, on every clock, whether a 32-bit core leaves its current flow for an exception or resumes a flow it left earlier. Seven request lines come in (reset request, undefined instruction, software interrupt, prefetch abort, data abort, IRQ, FIQ), along with a return request. The core also supplies its current program counter and status word.

When a request is accepted, the block does the following in a single clock edge:
- It banks the incoming status word and return address in the save slot of the target mode.
- It builds the new status word: mode switched, instruction-set bit cleared, interrupt masks raised.
- It points the program counter at the vector for that exception. The vector table sits in low or high memory, selected by a configuration input.

A return request reads back the save slot of the mode shown in the current status word and restores both values.

Each accepted event is announced by a one-cycle redirect strobe. The new PC and status word are held on the outputs, and the core applies them when it sees the strobe. While the strobe is high, the core has not yet applied the new state. For that reason every request presented in that cycle is dropped.

Top module: `exc_seq`

## Requirements
- R1: While rst_ni is low, and after it rises with no request, pc_o is 0x00000000, psr_o is 0x000000D3 (Supervisor mode, I and F set) and redirect_o is 0.
- R2: On entry, pc_o is the vector base plus an offset: reset 0x00, undefined 0x04, software interrupt 0x08, prefetch abort 0x0C, data abort 0x10, IRQ 0x18, FIQ 0x1C. The base is 0xFFFF0000 when hivec_i is 1 and 0x00000000 when it is 0.
- R3: Entry sets psr_o[4:0] to the target mode, with the mode codes user 0x10, FIQ 0x11, IRQ 0x12, Supervisor 0x13, Abort 0x17, Undefined 0x1B, System 0x1F. Reset request and software interrupt go to Supervisor; FIQ goes to FIQ; IRQ goes to IRQ; both aborts go to Abort; undefined goes to Undefined.
- R4: The entry status word copies psr_i bits 31:8 and bit 6. It then clears T (bit 5) and sets I (bit 7). It also sets F (bit 6) for a reset request or FIQ.
- R5: Entry stores psr_i, unmodified, in the saved-status slot of the target mode. A later return taken while psr_i[4:0] names that mode drives psr_o with the stored value.
- R6: Entry stores pc_i in the link slot of the target mode. A later return from that mode drives pc_o with the stored value.
- R7: Simultaneous requests are served in this order: reset request, data abort, FIQ, IRQ, prefetch abort, undefined, software interrupt. Any accepted exception wins over a return request.
- R8: An IRQ request is ignored while psr_i[7]=1, and an FIQ request is ignored while psr_i[6]=1.
- R9: redirect_o is high for exactly the one cycle after the edge that accepts an event. Every request present in a cycle where redirect_o is high is ignored.
- R10: A return request is ignored when psr_i[4:0] is not a banked mode (FIQ, IRQ, Supervisor, Abort, Undefined). When an event is ignored, no redirect occurs and pc_o and psr_o hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rst_req_i | input | 1 | Reset exception request |
| und_req_i | input | 1 | Undefined instruction request |
| swi_req_i | input | 1 | Software interrupt request |
| pabt_req_i | input | 1 | Prefetch abort request |
| dabt_req_i | input | 1 | Data abort request |
| irq_req_i | input | 1 | Normal interrupt request |
| fiq_req_i | input | 1 | Fast interrupt request |
| ret_req_i | input | 1 | Exception return request |
| hivec_i | input | 1 | Selects the high vector base |
| pc_i | input | 32 | Current PC, used as the return address |
| psr_i | input | 32 | Current status word |
| pc_o | output | 32 | New PC after entry or return |
| psr_o | output | 32 | New status word after entry or return |
| redirect_o | output | 1 | One-cycle strobe per accepted event |

## Verification
The hardest situation to bring about is a request arriving in the very cycle the redirect strobe is high. This happens when the core has not yet applied the new state, so a second event would otherwise bank stale values over a fresh slot. The bench reaches it in two ways: it presents a software interrupt on two consecutive cycles, and it holds an IRQ for three cycles. Its model then expects the second request to be dropped and the third to be taken. Return paths are checked after other entries have overwritten neighbouring save slots. This shows that each mode's slot is read back intact.

// File: rtl/exc_seq_pkg.sv
package exc_seq_pkg;
  typedef enum logic [4:0] {
    MODE_USR = 5'h10, MODE_FIQ = 5'h11, MODE_IRQ = 5'h12, MODE_SVC = 5'h13,
    MODE_ABT = 5'h17, MODE_UND = 5'h1B, MODE_SYS = 5'h1F
  } mode_e;

  // encoding is the vector slot index (offset = index * 4)
  typedef enum logic [2:0] {
    EXC_RST = 3'd0, EXC_UND = 3'd1, EXC_SWI = 3'd2, EXC_PABT = 3'd3,
    EXC_DABT = 3'd4, EXC_RSVD = 3'd5, EXC_IRQ = 3'd6, EXC_FIQ = 3'd7
  } exc_e;

  localparam int NEXC   = 8;
  localparam int NPRIO  = 7;
  localparam int NBANK  = 5;
  localparam int BANK_W = $clog2(NBANK);
  localparam logic [BANK_W-1:0] BANK_NONE = '1;

  // highest priority first
  localparam exc_e PRIO [NPRIO] = '{EXC_RST, EXC_DABT, EXC_FIQ, EXC_IRQ,
                                    EXC_PABT, EXC_UND, EXC_SWI};

  function automatic logic [BANK_W-1:0] bank_idx(input logic [4:0] m);
    case (m)
      MODE_FIQ: bank_idx = BANK_W'(0);
      MODE_IRQ: bank_idx = BANK_W'(1);
      MODE_SVC: bank_idx = BANK_W'(2);
      MODE_ABT: bank_idx = BANK_W'(3);
      MODE_UND: bank_idx = BANK_W'(4);
      default:  bank_idx = BANK_NONE;
    endcase
  endfunction

  function automatic mode_e exc_mode(input exc_e e);
    case (e)
      EXC_UND:           exc_mode = MODE_UND;
      EXC_PABT, EXC_DABT: exc_mode = MODE_ABT;
      EXC_IRQ:           exc_mode = MODE_IRQ;
      EXC_FIQ:           exc_mode = MODE_FIQ;
      default:           exc_mode = MODE_SVC;
    endcase
  endfunction
endpackage

// File: rtl/exc_arb.sv
module exc_arb
  import exc_seq_pkg::*;
(
  input  logic [NEXC-1:0] req_i,
  input  logic            irq_mask_i,
  input  logic            fiq_mask_i,
  input  logic            ret_i,
  input  logic            block_i,
  output logic            take_o,
  output logic            ret_o,
  output exc_e            exc_o
);
  logic [NEXC-1:0] live;

  always_comb begin
    live = req_i;
    live[EXC_IRQ]  = req_i[EXC_IRQ] & ~irq_mask_i;
    live[EXC_FIQ]  = req_i[EXC_FIQ] & ~fiq_mask_i;
    live[EXC_RSVD] = 1'b0;
    if (block_i) live = '0;
  end

  // walk lowest to highest so the highest live request wins
  always_comb begin
    take_o = 1'b0;
    exc_o  = EXC_RST;
    for (int k = NPRIO - 1; k >= 0; k--) begin
      if (live[PRIO[k]]) begin
        take_o = 1'b1;
        exc_o  = PRIO[k];
      end
    end
    ret_o = ret_i & ~block_i & ~take_o;
  end
endmodule

// File: rtl/exc_bank.sv
module exc_bank #(
  parameter int DATA_W = 32,
  parameter int NBANK  = 5,
  parameter int IDX_W  = $clog2(NBANK)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [IDX_W-1:0]  wr_idx_i,
  input  logic [DATA_W-1:0] spsr_wd_i,
  input  logic [DATA_W-1:0] lr_wd_i,
  input  logic [IDX_W-1:0]  rd_idx_i,
  output logic [DATA_W-1:0] spsr_rd_o,
  output logic [DATA_W-1:0] lr_rd_o
);
  logic [DATA_W-1:0] spsr_q [NBANK];
  logic [DATA_W-1:0] lr_q   [NBANK];

  for (genvar g = 0; g < NBANK; g++) begin : g_slot
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        spsr_q[g] <= '0;
        lr_q[g]   <= '0;
      end else if (wr_i && wr_idx_i == IDX_W'(g)) begin
        spsr_q[g] <= spsr_wd_i;
        lr_q[g]   <= lr_wd_i;
      end
    end
  end

  assign spsr_rd_o = spsr_q[rd_idx_i];
  assign lr_rd_o   = lr_q[rd_idx_i];

  // R5
  bank_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i |=> spsr_q[$past(wr_idx_i)] == $past(spsr_wd_i));
  // R6
  link_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i |=> lr_q[$past(wr_idx_i)] == $past(lr_wd_i));
endmodule

// File: rtl/exc_seq.sv
module exc_seq
  import exc_seq_pkg::*;
#(
  parameter int                 DATA_W  = 32,
  parameter logic [DATA_W-1:0]  LO_BASE = 32'h0000_0000,
  parameter logic [DATA_W-1:0]  HI_BASE = 32'hFFFF_0000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rst_req_i,
  input  logic              und_req_i,
  input  logic              swi_req_i,
  input  logic              pabt_req_i,
  input  logic              dabt_req_i,
  input  logic              irq_req_i,
  input  logic              fiq_req_i,
  input  logic              ret_req_i,
  input  logic              hivec_i,
  input  logic [DATA_W-1:0] pc_i,
  input  logic [DATA_W-1:0] psr_i,
  output logic [DATA_W-1:0] pc_o,
  output logic [DATA_W-1:0] psr_o,
  output logic              redirect_o
);
  localparam int FLAG_I = 7;
  localparam int FLAG_F = 6;
  localparam int FLAG_T = 5;
  localparam logic [DATA_W-1:0] RST_PSR =
    {{(DATA_W-8){1'b0}}, 1'b1, 1'b1, 1'b0, MODE_SVC};

  logic [NEXC-1:0]   req_vec;
  logic              take_entry, take_ret, ret_ok;
  exc_e              sel_exc;
  mode_e             tgt_mode;
  logic [BANK_W-1:0] cur_bank, tgt_bank;
  logic [DATA_W-1:0] entry_psr, vec_addr, spsr_rd, lr_rd;
  logic [DATA_W-1:0] pc_q, psr_q;
  logic              redirect_q;

  always_comb begin
    req_vec           = '0;
    req_vec[EXC_RST]  = rst_req_i;
    req_vec[EXC_UND]  = und_req_i;
    req_vec[EXC_SWI]  = swi_req_i;
    req_vec[EXC_PABT] = pabt_req_i;
    req_vec[EXC_DABT] = dabt_req_i;
    req_vec[EXC_IRQ]  = irq_req_i;
    req_vec[EXC_FIQ]  = fiq_req_i;
  end

  assign cur_bank = bank_idx(psr_i[4:0]);
  assign ret_ok   = cur_bank != BANK_NONE;

  exc_arb i_arb (
    .req_i      (req_vec),
    .irq_mask_i (psr_i[FLAG_I]),
    .fiq_mask_i (psr_i[FLAG_F]),
    .ret_i      (ret_req_i & ret_ok),
    .block_i    (redirect_q),
    .take_o     (take_entry),
    .ret_o      (take_ret),
    .exc_o      (sel_exc)
  );

  assign tgt_mode = exc_mode(sel_exc);
  assign tgt_bank = bank_idx(tgt_mode);

  always_comb begin
    entry_psr         = psr_i;
    entry_psr[FLAG_T] = 1'b0;
    entry_psr[FLAG_I] = 1'b1;
    if (sel_exc == EXC_RST || sel_exc == EXC_FIQ) entry_psr[FLAG_F] = 1'b1;
    entry_psr[4:0]    = tgt_mode;
  end

  assign vec_addr = (hivec_i ? HI_BASE : LO_BASE) | DATA_W'({sel_exc, 2'b00});

  exc_bank #(.DATA_W(DATA_W), .NBANK(NBANK), .IDX_W(BANK_W)) i_bank (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_i      (take_entry),
    .wr_idx_i  (tgt_bank),
    .spsr_wd_i (psr_i),
    .lr_wd_i   (pc_i),
    .rd_idx_i  (cur_bank),
    .spsr_rd_o (spsr_rd),
    .lr_rd_o   (lr_rd)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pc_q       <= LO_BASE;
      psr_q      <= RST_PSR;
      redirect_q <= 1'b0;
    end else begin
      redirect_q <= take_entry | take_ret;
      if (take_entry) begin
        pc_q  <= vec_addr;
        psr_q <= entry_psr;
      end else if (take_ret) begin
        pc_q  <= lr_rd;
        psr_q <= spsr_rd;
      end
    end
  end

  assign pc_o       = pc_q;
  assign psr_o      = psr_q;
  assign redirect_o = redirect_q;

  // R9
  redirect_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    redirect_o |=> !redirect_o);
  // R4
  entry_psr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_entry |=> redirect_o && !psr_o[FLAG_T] && psr_o[FLAG_I]);
  // R2
  hivec_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_entry && hivec_i |=> pc_o[DATA_W-1:16] == HI_BASE[DATA_W-1:16]);
  // R8
  irq_mask_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_req_i && psr_i[FLAG_I] && !rst_req_i && !und_req_i && !swi_req_i &&
    !pabt_req_i && !dabt_req_i && !fiq_req_i && !ret_req_i |=> !redirect_o);
  // R10
  ret_nobank_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ret_req_i && !ret_ok && !rst_req_i && !und_req_i && !swi_req_i &&
    !pabt_req_i && !dabt_req_i && !irq_req_i && !fiq_req_i
    |=> !redirect_o && $stable(pc_o) && $stable(psr_o));
endmodule

// File: tb/test_exc_seq.sv
module test_exc_seq;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b1;
  logic rq_rst = 0, rq_und = 0, rq_swi = 0, rq_pabt = 0, rq_dabt = 0;
  logic rq_irq = 0, rq_fiq = 0, rq_ret = 0, hv = 0;
  logic [31:0] pc_in = '0, psr_in = 32'h10;
  logic [31:0] pc_o, psr_o;
  logic        redirect_o;

  int n_tests = 0, n_fail = 0;
  bit done = 0;
  string cur_tag = "R1 idle", m_tag = "R1 reset";

  logic [31:0] m_pc, m_psr;
  logic        m_red;
  logic [31:0] m_spsr [int];
  logic [31:0] m_lr   [int];
  int code, mode;

  always #(CLK_PERIOD/2) clk = ~clk;

  exc_seq i_exc_seq (
    .clk_i(clk), .rst_ni(rst_n),
    .rst_req_i(rq_rst), .und_req_i(rq_und), .swi_req_i(rq_swi),
    .pabt_req_i(rq_pabt), .dabt_req_i(rq_dabt), .irq_req_i(rq_irq),
    .fiq_req_i(rq_fiq), .ret_req_i(rq_ret), .hivec_i(hv),
    .pc_i(pc_in), .psr_i(psr_in),
    .pc_o(pc_o), .psr_o(psr_o), .redirect_o(redirect_o)
  );

  // behavioural reference
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_pc = 32'h0; m_psr = 32'hD3; m_red = 1'b0; m_tag = "R1 reset";
      m_spsr[32'h11] = 0; m_spsr[32'h12] = 0; m_spsr[32'h13] = 0;
      m_spsr[32'h17] = 0; m_spsr[32'h1B] = 0;
      m_lr[32'h11] = 0; m_lr[32'h12] = 0; m_lr[32'h13] = 0;
      m_lr[32'h17] = 0; m_lr[32'h1B] = 0;
    end else begin
      m_tag = cur_tag;
      if (m_red) m_red = 1'b0;
      else begin
        code = -1;
        if (rq_rst) code = 0;
        else if (rq_dabt) code = 4;
        else if (rq_fiq && !psr_in[6]) code = 7;
        else if (rq_irq && !psr_in[7]) code = 6;
        else if (rq_pabt) code = 3;
        else if (rq_und) code = 1;
        else if (rq_swi) code = 2;
        if (code >= 0) begin
          case (code)
            0, 2: mode = 32'h13;
            1: mode = 32'h1B;
            6: mode = 32'h12;
            7: mode = 32'h11;
            default: mode = 32'h17;
          endcase
          m_spsr[mode] = psr_in;
          m_lr[mode] = pc_in;
          m_psr = {psr_in[31:8], 1'b1, psr_in[6] | (code == 0 || code == 7),
                   1'b0, mode[4:0]};
          m_pc = (hv ? 32'hFFFF_0000 : 32'h0) + 32'(code * 4);
          m_red = 1'b1;
        end else if (rq_ret && m_spsr.exists(int'(psr_in[4:0]))) begin
          m_psr = m_spsr[int'(psr_in[4:0])];
          m_pc  = m_lr[int'(psr_in[4:0])];
          m_red = 1'b1;
        end
      end
    end
  end

  task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL [%s] %s actual=%h expected=%h", m_tag, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (!done) begin
      chk("pc_o", pc_o, m_pc);
      chk("psr_o", psr_o, m_psr);
      chk("redirect_o", {31'b0, redirect_o}, {31'b0, m_red});
    end
  end

  task automatic put(input logic [7:0] r, input logic [31:0] pc, input logic [31:0] psr,
                     input logic h, input string tag);
    @(negedge clk);
    #1;
    {rq_rst, rq_dabt, rq_fiq, rq_irq, rq_pabt, rq_und, rq_swi, rq_ret} = r;
    pc_in = pc; psr_in = psr; hv = h; cur_tag = tag;
  endtask

  // request bit order: rst dabt fiq irq pabt und swi ret
  initial begin
    #1 rst_n = 1'b0;
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    put(8'h00, 32'h0, 32'h10, 0, "R1 idle after reset");
    put(8'h00, 32'h0, 32'h10, 0, "R1 idle after reset");
    put(8'b0001_0000, 32'h1000, 32'h6000_0010, 0, "R2 R3 R4 irq entry");
    put(8'h00, 32'h0, 32'h6000_0092, 0, "R9 idle");
    put(8'b0000_0001, 32'h0, 32'h6000_0092, 0, "R5 R6 return from irq");
    put(8'h00, 32'h0, 32'h10, 0, "R9 idle");
    put(8'b0010_0000, 32'h2000, 32'h8000_0030, 1, "R2 R4 fiq high vector");
    put(8'h00, 32'h0, 32'h10, 0, "R9 idle");
    put(8'b0001_0000, 32'h2100, 32'h0000_0090, 0, "R8 irq masked");
    put(8'b0010_0000, 32'h2200, 32'h0000_0050, 0, "R8 fiq masked");
    put(8'b1111_1111, 32'h2300, 32'h0000_0010, 0, "R7 reset wins");
    put(8'h00, 32'h0, 32'h10, 0, "R9 idle");
    put(8'b0111_1110, 32'h2400, 32'h0000_0010, 1, "R7 data abort wins");
    put(8'h00, 32'h0, 32'h10, 0, "R9 idle");
    put(8'b0011_1111, 32'h2500, 32'h0000_0010, 0, "R7 fiq wins");
    put(8'h00, 32'h0, 32'h10, 0, "R9 idle");
    put(8'b0011_1110, 32'h2600, 32'h0000_0050, 0, "R7 R8 irq wins over masked fiq");
    put(8'h00, 32'h0, 32'h10, 0, "R9 idle");
    put(8'b0001_1100, 32'h2700, 32'h0000_0010, 0, "R7 irq wins");
    put(8'h00, 32'h0, 32'h10, 0, "R9 idle");
    put(8'b0000_1110, 32'h2800, 32'h0000_0010, 1, "R7 prefetch abort wins");
    put(8'h00, 32'h0, 32'h10, 0, "R9 idle");
    put(8'b0000_0110, 32'h2900, 32'h0000_0010, 0, "R7 R3 undefined wins");
    put(8'h00, 32'h0, 32'h10, 0, "R9 idle");
    put(8'b0000_0010, 32'h3000, 32'h2000_001F, 0, "R3 swi from system");
    put(8'b0000_0010, 32'h3100, 32'h2000_001F, 0, "R9 request during strobe");
    put(8'h00, 32'h0, 32'h13, 0, "R9 idle");
    put(8'b0000_0001, 32'h0, 32'h0000_00D3, 0, "R5 R6 return from supervisor");
    put(8'h00, 32'h0, 32'h10, 0, "R9 idle");
    put(8'b0000_0001, 32'h0, 32'h0000_0010, 0, "R10 return from user ignored");
    put(8'b0000_0001, 32'h0, 32'h0000_001F, 0, "R10 return from system ignored");
    put(8'b0001_0001, 32'h4000, 32'h0000_0010, 0, "R7 exception over return");
    put(8'h00, 32'h0, 32'h10, 0, "R9 idle");
    put(8'b0001_0000, 32'h5000, 32'h1000_0010, 0, "R9 held irq cycle 1");
    put(8'b0001_0000, 32'h5004, 32'h1000_0010, 0, "R9 held irq cycle 2");
    put(8'b0001_0000, 32'h5008, 32'h1000_0010, 0, "R9 held irq cycle 3");
    put(8'h00, 32'h0, 32'h10, 0, "R9 idle");
    put(8'b0000_0001, 32'h0, 32'h0000_0097, 0, "R5 R6 return from abort");
    put(8'h00, 32'h0, 32'h10, 0, "R9 idle");
    put(8'b0000_0001, 32'h0, 32'h0000_00DB, 0, "R5 R6 return from undefined");
    put(8'h00, 32'h0, 32'h10, 0, "R9 idle");
    put(8'b0000_0001, 32'h0, 32'h0000_00D1, 0, "R5 R6 return from fiq");
    put(8'h00, 32'h0, 32'h10, 0, "R9 idle");
    put(8'h00, 32'h0, 32'h10, 0, "R9 idle");
    @(negedge clk);
    #2 done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_tests++;
      n_fail++;
      $display("FAIL watchdog expired (R1..) actual=running expected=finished");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule